// File: doc/BRIEF.md
# Hashed Inverted Page Table Search

This block translates a process id and virtual page number into a physical frame. It searches an inverted page table that holds one entry per physical frame, so the table depth depends only on the number of frames. The frame number is not read out of an entry. It is the position of the entry whose stored process id and virtual page both equal the key.

The search does not begin at entry zero. The key is folded with XOR to a frame-index-wide value, and probing starts there. Each clock cycle the block moves one entry forward and wraps from the last frame back to frame 0. It stops at the first valid match, at the first invalid entry, or when its probe budget is used up. A hit marks the entry as referenced. A hit from a store also marks it as modified. A store to an entry that is not writable returns a protection fault.

Software fills the table through a write port that sets every field of one entry. A registered read port returns any entry, including the reference and modified bits that lookups change. The translation side is a simple request/response handshake that handles one lookup at a time.

Top module: `iptab_search`

## Requirements
- R1: The first probed frame is the XOR-fold of the key {pid, vpn}, with pid in the upper bits. Key bit i is XORed into index bit (i mod FRAME_W), and all bits not covered by the key are zero.
- R2: When the probed entry is valid and its pid and vpn both equal the key, the response has rsp_hit=1 and rsp_frame equal to that entry's index. rsp_paddr is {rsp_frame, req_off}.
- R3: After a valid non-matching entry, the next probe is the following index. The index after frame 2^FRAME_W-1 is frame 0.
- R4: An invalid entry ends the search as a miss (rsp_hit=0, rsp_fault=0). rsp_probes counts that entry.
- R5: A search never exceeds MAX_PROBE probes. When MAX_PROBE entries have been probed without a match or an invalid entry, it ends as a miss with rsp_probes=MAX_PROBE. rsp_probes is always at least 1.
- R6: A hit sets the entry's reference bit (flag bit 4). A hit with req_write=1 also sets its modified bit (flag bit 5).
- R7: A matching entry with its write bit (flag bit 1) clear, looked up with req_write=1, returns rsp_fault=1 and rsp_hit=0. Its reference and modified bits are left unchanged.
- R8: req_ready is high only while the block is idle. Each accepted request produces exactly one rsp_valid pulse, one cycle wide, with rsp_valid occurring MAX_PROBE or fewer cycles after acceptance.
- R9: A table write stores pid, vpn and the six flag bits {m,f,x,r,w,v} (bit 0 = valid) at tbl_idx. The read port returns them one cycle after rd_idx is presented.
- R10: After reset, every entry is invalid, req_ready=1 and rsp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_pid | input | PID_W | Process id of the key |
| req_vpn | input | VPN_W | Virtual page number of the key |
| req_off | input | OFF_W | Page offset carried into the physical address |
| req_write | input | 1 | Lookup is for a store |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Matching, permitted entry found |
| rsp_fault | output | 1 | Matching entry forbids the store |
| rsp_frame | output | FRAME_W | Index of the last probed entry (frame on hit) |
| rsp_paddr | output | FRAME_W+OFF_W | {frame, offset} |
| rsp_probes | output | CNT_W | Entries examined by this search |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | FRAME_W | Entry written |
| tbl_pid | input | PID_W | Process id written |
| tbl_vpn | input | VPN_W | Virtual page written |
| tbl_flags | input | 6 | {m,f,x,r,w,v} written |
| rd_idx | input | FRAME_W | Entry to read back |
| rd_pid | output | PID_W | Read-back process id |
| rd_vpn | output | VPN_W | Read-back virtual page |
| rd_flags | output | 6 | Read-back {m,f,x,r,w,v} |

## Verification
Directed keys each exercise one way a search can end. An empty table shows that an invalid entry stops the walk after one probe. A fully occupied table with no matching entry shows that the probe budget caps the walk. A collision placed at the last frame shows the wrap to frame 0. A store to a read-only entry shows the fault and that its flags stay unchanged. Random phases then fill the table with many colliding keys from small pid and vpn ranges and mix loads and stores. The probe count and frame separate a wrong hash or wrong step from a correct one, and flag read-back after each hit shows whether the reference and modified bits were updated.

// File: rtl/iptab_pkg.sv
package iptab_pkg;
  // Flag vector layout shared by table port and walker
  localparam int FLG_V = 0;
  localparam int FLG_W = 1;
  localparam int FLG_R = 2;
  localparam int FLG_X = 3;
  localparam int FLG_F = 4;
  localparam int FLG_M = 5;
  localparam int FLG_N = 6;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_PROBE = 1'b1
  } walk_state_e;
endpackage

// File: rtl/iptab_hash.sv
module iptab_hash #(
  parameter int PID_W = 8,
  parameter int VPN_W = 12,
  parameter int IDX_W = 4
) (
  input  logic [PID_W-1:0] pid,
  input  logic [VPN_W-1:0] vpn,
  output logic [IDX_W-1:0] idx
);
  localparam int KEY_W  = PID_W + VPN_W;
  localparam int NCHUNK = (KEY_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = NCHUNK * IDX_W;

  logic [PAD_W-1:0] key_pad;
  logic [IDX_W-1:0] fold [NCHUNK+1];

  assign key_pad = PAD_W'({pid, vpn});
  assign fold[0] = '0;

  for (genvar g = 0; g < NCHUNK; g++) begin : g_fold
    assign fold[g+1] = fold[g] ^ key_pad[g*IDX_W +: IDX_W];
  end

  assign idx = fold[NCHUNK];
endmodule

// File: rtl/iptab_store.sv
module iptab_store
  import iptab_pkg::*;
#(
  parameter int PID_W = 8,
  parameter int VPN_W = 12,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [FLG_N-1:0]  wr_flags,
  input  logic [IDX_W-1:0]  probe_idx,
  output logic [PID_W-1:0]  probe_pid,
  output logic [VPN_W-1:0]  probe_vpn,
  output logic              probe_v,
  output logic              probe_w,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic              upd_mod,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [PID_W-1:0]  rd_pid,
  output logic [VPN_W-1:0]  rd_vpn,
  output logic [FLG_N-1:0]  rd_flags
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ROW_W = PID_W + VPN_W + 3;   // pid, vpn, x, r, w

  // Static fields: no reset, one write port, so it maps to distributed RAM
  logic [ROW_W-1:0] ram [DEPTH];
  // Dynamic bits: registers with reset
  logic [DEPTH-1:0] valid_q, ref_q, mod_q;

  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_idx] <= {wr_pid, wr_vpn, wr_flags[FLG_X], wr_flags[FLG_R], wr_flags[FLG_W]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      ref_q   <= '0;
      mod_q   <= '0;
    end else begin
      if (upd_en) begin
        ref_q[upd_idx] <= 1'b1;
        if (upd_mod) mod_q[upd_idx] <= 1'b1;
      end
      if (wr_en) begin          // table port wins on a same-entry collision
        valid_q[wr_idx] <= wr_flags[FLG_V];
        ref_q[wr_idx]   <= wr_flags[FLG_F];
        mod_q[wr_idx]   <= wr_flags[FLG_M];
      end
    end
  end

  logic [ROW_W-1:0] prow, rrow;
  assign prow      = ram[probe_idx];
  assign probe_pid = prow[ROW_W-1 -: PID_W];
  assign probe_vpn = prow[3 +: VPN_W];
  assign probe_w   = prow[0];
  assign probe_v   = valid_q[probe_idx];

  assign rrow = ram[rd_idx];
  always_ff @(posedge clk) begin
    rd_pid   <= rrow[ROW_W-1 -: PID_W];
    rd_vpn   <= rrow[3 +: VPN_W];
    rd_flags <= {mod_q[rd_idx], ref_q[rd_idx], rrow[2], rrow[1], rrow[0], valid_q[rd_idx]};
  end

  p_ref_set_r6: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !(wr_en && wr_idx == upd_idx)) |=> ref_q[$past(upd_idx)]);

  p_mod_set_r6: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_mod && !(wr_en && wr_idx == upd_idx)) |=> mod_q[$past(upd_idx)]);

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_flags[FLG_V]) |=> !valid_q[$past(wr_idx)]);
endmodule

// File: rtl/iptab_walker.sv
module iptab_walker
  import iptab_pkg::*;
#(
  parameter int PID_W     = 8,
  parameter int VPN_W     = 12,
  parameter int IDX_W     = 4,
  parameter int OFF_W     = 12,
  parameter int MAX_PROBE = 6,
  localparam int CNT_W    = $clog2(MAX_PROBE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PID_W-1:0]  req_pid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [OFF_W-1:0]  req_off,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  hash_idx,
  output logic [IDX_W-1:0]  probe_idx,
  input  logic [PID_W-1:0]  probe_pid,
  input  logic [VPN_W-1:0]  probe_vpn,
  input  logic              probe_v,
  input  logic              probe_w,
  output logic              upd_en,
  output logic [IDX_W-1:0]  upd_idx,
  output logic              upd_mod,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [IDX_W-1:0]  rsp_frame,
  output logic [IDX_W+OFF_W-1:0] rsp_paddr,
  output logic [CNT_W-1:0]  rsp_probes
);
  walk_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [PID_W-1:0] pid_q;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic             wr_q;
  logic             match, perm_ok, budget_out, done;

  assign match      = probe_v && (probe_pid == pid_q) && (probe_vpn == vpn_q);
  assign perm_ok    = !wr_q || probe_w;
  assign cnt_nx     = cnt_q + 1'b1;
  assign budget_out = (cnt_nx == CNT_W'(MAX_PROBE));
  assign done       = (state_q == ST_PROBE) && (!probe_v || match || budget_out);

  assign req_ready = (state_q == ST_IDLE);
  assign probe_idx = idx_q;
  assign upd_en    = (state_q == ST_PROBE) && match && perm_ok;
  assign upd_idx   = idx_q;
  assign upd_mod   = wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      cnt_q      <= '0;
      pid_q      <= '0;
      vpn_q      <= '0;
      off_q      <= '0;
      wr_q       <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_frame  <= '0;
      rsp_paddr  <= '0;
      rsp_probes <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            pid_q   <= req_pid;
            vpn_q   <= req_vpn;
            off_q   <= req_off;
            wr_q    <= req_write;
            idx_q   <= hash_idx;
            cnt_q   <= '0;
            state_q <= ST_PROBE;
          end
        end
        ST_PROBE: begin
          if (done) begin
            rsp_valid  <= 1'b1;
            rsp_hit    <= match && perm_ok;
            rsp_fault  <= match && !perm_ok;
            rsp_frame  <= idx_q;
            rsp_paddr  <= {idx_q, off_q};
            rsp_probes <= cnt_nx;
            state_q    <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;     // wraps at the table end
            cnt_q <= cnt_nx;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_start_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (probe_idx == $past(hash_idx)));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PROBE && !done) |=> (probe_idx == $past(probe_idx) + 1'b1));

  p_probe_bound_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_probes >= 1 && rsp_probes <= CNT_W'(MAX_PROBE)));

  p_fault_excl_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> !rsp_hit);

  p_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_reset_r10: assert property (@(posedge clk)
    $past(rst) |-> (!rsp_valid && req_ready));
endmodule

// File: rtl/iptab_search.sv
module iptab_search
  import iptab_pkg::*;
#(
  parameter int PID_W     = 8,
  parameter int VPN_W     = 12,
  parameter int FRAME_W   = 4,
  parameter int OFF_W     = 12,
  parameter int MAX_PROBE = 6,
  localparam int CNT_W    = $clog2(MAX_PROBE + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [PID_W-1:0]         req_pid,
  input  logic [VPN_W-1:0]         req_vpn,
  input  logic [OFF_W-1:0]         req_off,
  input  logic                     req_write,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic                     rsp_fault,
  output logic [FRAME_W-1:0]       rsp_frame,
  output logic [FRAME_W+OFF_W-1:0] rsp_paddr,
  output logic [CNT_W-1:0]         rsp_probes,
  input  logic                     tbl_we,
  input  logic [FRAME_W-1:0]       tbl_idx,
  input  logic [PID_W-1:0]         tbl_pid,
  input  logic [VPN_W-1:0]         tbl_vpn,
  input  logic [5:0]               tbl_flags,
  input  logic [FRAME_W-1:0]       rd_idx,
  output logic [PID_W-1:0]         rd_pid,
  output logic [VPN_W-1:0]         rd_vpn,
  output logic [5:0]               rd_flags
);
  logic [FRAME_W-1:0] hash_idx, probe_idx, upd_idx;
  logic [PID_W-1:0]   probe_pid;
  logic [VPN_W-1:0]   probe_vpn;
  logic               probe_v, probe_w, upd_en, upd_mod;

  iptab_hash #(.PID_W(PID_W), .VPN_W(VPN_W), .IDX_W(FRAME_W)) hash_i (
    .pid (req_pid),
    .vpn (req_vpn),
    .idx (hash_idx)
  );

  iptab_store #(.PID_W(PID_W), .VPN_W(VPN_W), .IDX_W(FRAME_W)) store_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (tbl_we),
    .wr_idx    (tbl_idx),
    .wr_pid    (tbl_pid),
    .wr_vpn    (tbl_vpn),
    .wr_flags  (tbl_flags),
    .probe_idx (probe_idx),
    .probe_pid (probe_pid),
    .probe_vpn (probe_vpn),
    .probe_v   (probe_v),
    .probe_w   (probe_w),
    .upd_en    (upd_en),
    .upd_idx   (upd_idx),
    .upd_mod   (upd_mod),
    .rd_idx    (rd_idx),
    .rd_pid    (rd_pid),
    .rd_vpn    (rd_vpn),
    .rd_flags  (rd_flags)
  );

  iptab_walker #(
    .PID_W(PID_W), .VPN_W(VPN_W), .IDX_W(FRAME_W),
    .OFF_W(OFF_W), .MAX_PROBE(MAX_PROBE)
  ) walk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_pid    (req_pid),
    .req_vpn    (req_vpn),
    .req_off    (req_off),
    .req_write  (req_write),
    .hash_idx   (hash_idx),
    .probe_idx  (probe_idx),
    .probe_pid  (probe_pid),
    .probe_vpn  (probe_vpn),
    .probe_v    (probe_v),
    .probe_w    (probe_w),
    .upd_en     (upd_en),
    .upd_idx    (upd_idx),
    .upd_mod    (upd_mod),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_fault  (rsp_fault),
    .rsp_frame  (rsp_frame),
    .rsp_paddr  (rsp_paddr),
    .rsp_probes (rsp_probes)
  );
endmodule

// File: tb/iptab_search_tb_top.sv
`timescale 1ns/1ps
module iptab_search_tb_top;
  localparam int PID_W = 8, VPN_W = 12, FRAME_W = 4, OFF_W = 12, MAX_PROBE = 6;
  localparam int CNT_W = $clog2(MAX_PROBE + 1);
  localparam int DEPTH = 1 << FRAME_W;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0, tbl_we = 0;
  logic [PID_W-1:0] req_pid = '0, tbl_pid = '0;
  logic [VPN_W-1:0] req_vpn = '0, tbl_vpn = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [FRAME_W-1:0] tbl_idx = '0, rd_idx = '0;
  logic [5:0] tbl_flags = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_fault;
  logic [FRAME_W-1:0] rsp_frame;
  logic [FRAME_W+OFF_W-1:0] rsp_paddr;
  logic [CNT_W-1:0] rsp_probes;
  logic [PID_W-1:0] rd_pid;
  logic [VPN_W-1:0] rd_vpn;
  logic [5:0] rd_flags;

  always #2.5 clk = ~clk;

  iptab_search #(.PID_W(PID_W), .VPN_W(VPN_W), .FRAME_W(FRAME_W),
                 .OFF_W(OFF_W), .MAX_PROBE(MAX_PROBE)) dut_i (.*);

  int n_chk = 0, n_err = 0;
  bit done_f = 0;
  logic [PID_W-1:0] m_pid [DEPTH];
  logic [VPN_W-1:0] m_vpn [DEPTH];
  logic [5:0]       m_flg [DEPTH];
  logic [PID_W-1:0] k_pid [64];
  logic [VPN_W-1:0] k_vpn [64];
  int n_keys = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [FRAME_W-1:0] fold(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v);
    logic [PID_W+VPN_W-1:0] k = {p, v};
    logic [FRAME_W-1:0] h = '0;
    for (int i = 0; i < PID_W + VPN_W; i++) h[i % FRAME_W] ^= k[i];
    return h;
  endfunction

  task automatic tbl_write(input int idx, input logic [PID_W-1:0] p,
                           input logic [VPN_W-1:0] v, input logic [5:0] f);
    @(negedge clk);
    tbl_we = 1; tbl_idx = FRAME_W'(idx); tbl_pid = p; tbl_vpn = v; tbl_flags = f;
    @(negedge clk);
    tbl_we = 0;
    m_pid[idx] = p; m_vpn[idx] = v; m_flg[idx] = f;
  endtask

  task automatic clear_all();
    for (int i = 0; i < DEPTH; i++) tbl_write(i, '0, '0, 6'b0);
  endtask

  task automatic read_check(input int idx, input string tag);
    @(negedge clk);
    rd_idx = FRAME_W'(idx);
    @(negedge clk);
    chk(tag, {26'd0, rd_flags}, {26'd0, m_flg[idx]});
  endtask

  // Model of one search; updates model flags on a hit
  task automatic predict(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v, input bit wr,
                         output bit hit, output bit flt, output int frame, output int probes);
    int h = int'(fold(p, v));
    hit = 0; flt = 0; frame = 0; probes = MAX_PROBE;
    for (int k = 0; k < MAX_PROBE; k++) begin
      int i = (h + k) % DEPTH;
      if (!m_flg[i][0]) begin probes = k + 1; return; end
      if (m_pid[i] == p && m_vpn[i] == v) begin
        probes = k + 1; frame = i;
        if (wr && !m_flg[i][1]) flt = 1;
        else begin
          hit = 1; m_flg[i][4] = 1'b1;
          if (wr) m_flg[i][5] = 1'b1;
        end
        return;
      end
    end
  endtask

  task automatic lookup(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v,
                        input bit wr, input logic [OFF_W-1:0] off, input string tag);
    bit hit, flt, seen;
    int frame, probes;
    predict(p, v, wr, hit, flt, frame, probes);
    @(negedge clk);
    chk({tag, " R8 ready idle"}, {31'd0, req_ready}, 32'd1);
    req_valid = 1; req_pid = p; req_vpn = v; req_write = wr; req_off = off;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R8 busy"}, {31'd0, req_ready}, 32'd0);
    seen = 0;
    for (int c = 0; c < MAX_PROBE + 2 && !seen; c++) begin
      if (rsp_valid) seen = 1; else @(negedge clk);
    end
    chk({tag, " R8 response"}, {31'd0, seen}, 32'd1);
    if (seen) begin
      chk({tag, " R2 R4 hit"}, {31'd0, rsp_hit}, {31'd0, hit});
      chk({tag, " R7 fault"}, {31'd0, rsp_fault}, {31'd0, flt});
      chk({tag, " R1 R3 R5 probes"}, 32'(rsp_probes), 32'(probes));
      if (hit || flt) begin
        chk({tag, " R2 frame"}, 32'(rsp_frame), 32'(frame));
        chk({tag, " R2 paddr"}, 32'(rsp_paddr), 32'({FRAME_W'(frame), off}));
      end
      @(negedge clk);
      chk({tag, " R8 single pulse"}, {31'd0, rsp_valid}, 32'd0);
      if (hit || flt) read_check(frame, {tag, " R6 R7 flags"});
    end
  endtask

  task automatic install(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v, input logic [5:0] f);
    int h = int'(fold(p, v));
    for (int k = 0; k < MAX_PROBE; k++) begin
      int i = (h + k) % DEPTH;
      if (m_flg[i][0] && m_pid[i] == p && m_vpn[i] == v) return;
      if (!m_flg[i][0]) begin
        tbl_write(i, p, v, f);
        if (n_keys < 64) begin k_pid[n_keys] = p; k_vpn[n_keys] = v; n_keys++; end
        return;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_f) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < DEPTH; i++) begin m_pid[i] = '0; m_vpn[i] = '0; m_flg[i] = '0; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10: reset state
    chk("R10 ready", {31'd0, req_ready}, 32'd1);
    chk("R10 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    for (int i = 0; i < DEPTH; i++) begin
      rd_idx = FRAME_W'(i);
      @(negedge clk);
      chk("R10 entry invalid", {31'd0, rd_flags[0]}, 32'd0);
    end
    clear_all();

    // R4: empty table, miss after one probe
    lookup(8'h12, 12'h345, 0, 12'h0AB, "empty");

    // R9: write/read back of all fields
    tbl_write(5, 8'hA5, 12'h5C3, 6'b000111);
    @(negedge clk); rd_idx = 4'd5; @(negedge clk);
    chk("R9 pid", 32'(rd_pid), 32'hA5);
    chk("R9 vpn", 32'(rd_vpn), 32'h5C3);
    chk("R9 flags", 32'(rd_flags), 32'h07);
    clear_all();

    // R3: wrap from last frame to frame 0 (pid 0, vpn 0x00F folds to 15)
    tbl_write(15, 8'h01, 12'h111, 6'b000111);
    tbl_write(0, 8'h00, 12'h00F, 6'b000111);
    lookup(8'h00, 12'h00F, 0, 12'h123, "wrap R3");
    // R6: store hit sets modified
    lookup(8'h00, 12'h00F, 1, 12'h456, "store R6");
    // R7: read-only entry faults on store
    tbl_write(3, 8'h00, 12'h003, 6'b000101);
    lookup(8'h00, 12'h003, 1, 12'h777, "ro R7");
    lookup(8'h00, 12'h003, 0, 12'h778, "ro load R6");

    // R5: full table with no match, budget caps the walk
    for (int i = 0; i < DEPTH; i++) tbl_write(i, 8'hFF, 12'(i), 6'b000111);
    lookup(8'h00, 12'h000, 0, 12'h001, "full R5");
    lookup(8'h3C, 12'hA0E, 1, 12'h002, "full2 R5");

    // Random phases with colliding keys
    for (int ph = 0; ph < 3; ph++) begin
      clear_all();
      n_keys = 0;
      for (int j = 0; j < 12 + 2 * ph; j++)
        install(PID_W'($urandom_range(3)), VPN_W'($urandom_range(15)),
                {2'b00, 1'b0, 1'b1, 1'($urandom_range(1)), 1'b1});
      for (int j = 0; j < 80; j++) begin
        logic [PID_W-1:0] p;
        logic [VPN_W-1:0] v;
        if (n_keys > 0 && $urandom_range(9) < 7) begin
          int s = $urandom_range(n_keys - 1);
          p = k_pid[s]; v = k_vpn[s];
        end else begin
          p = PID_W'($urandom_range(3)); v = VPN_W'($urandom_range(15));
        end
        lookup(p, v, 1'($urandom_range(1)), OFF_W'($urandom), "random R1 R2 R3");
      end
    end

    done_f = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule